// File: doc/BRIEF.md
# Segment and Privilege Address Checker

This block is the first stage of address translation. It looks at a virtual address before any translation lookaside buffer is consulted. From a status word it works out the privilege level of the access. It then places the address in one of three classes: the cached unmapped kernel window, the uncached unmapped kernel window, or the mapped space.

For the two unmapped windows the block produces the physical address itself and raises a bypass flag. For the mapped space it raises a flag that sends the access on to the translation buffer. It also catches two kinds of address error: an access that is misaligned for its size, and an access to the cached kernel window from a level other than kernel. On an error it reports the offending virtual address and whether the error was caused by a store. Separately, it marks accesses whose address selects the uncached attribute.

The block is purely combinational: every output follows its inputs within the same cycle, with no state. It sits in front of the translation buffer, and the fault logic downstream reads its flags directly.

Top module: `seg_priv_check`

## Requirements
- R1: The access runs at kernel level if any of status bits 28, 2 or 1 is set, or if status field [4:3] is 2'b00.
- R2: When R1 does not apply, status field [4:3] selects the level: 2'b01 is supervisor, 2'b10 is user, and 2'b11 is an undefined level. None of these three is kernel level.
- R3: `size_code` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. An access whose address has any bit set below that width raises `addr_err`.
- R4: An access to 0x80000000–0x9FFFFFFF at any level other than kernel raises `addr_err`. An access to 0xA0000000–0xBFFFFFFF never raises an error on privilege grounds.
- R5: For addresses in 0x80000000–0xBFFFFFFF, `bypass` is 1 and `phys_addr` is the virtual address with bits [31:29] cleared. This holds even when an error is flagged. Outside that range, `bypass` is 0 and `phys_addr` is 0.
- R6: `err_store` is 1 exactly when `addr_err` is 1 and `acc_kind` is 2'b10 (store). The other codes are 2'b00 fetch, 2'b01 load, and 2'b11, which is treated as a load.
- R7: `bad_vaddr` equals `vaddr` while `addr_err` is 1, and is 0 otherwise.
- R8: `uncacheable` is 1 when virtual address bits 31 and 29 are both set and no address error is flagged.
- R9: `to_tlb` is 1 exactly when the address lies outside 0x80000000–0xBFFFFFFF and no address error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address of the access |
| size_code | input | 2 | Access width code (1, 2, 4 or 8 bytes) |
| acc_kind | input | 2 | Access type: fetch, load or store |
| status_word | input | 32 | Processor status word carrying the privilege fields |
| bypass | output | 1 | Address lies in an unmapped kernel window |
| phys_addr | output | 32 | Direct physical address for an unmapped window |
| addr_err | output | 1 | Address error: misaligned, or privilege violation |
| err_store | output | 1 | The address error was raised by a store |
| bad_vaddr | output | 32 | Faulting virtual address |
| uncacheable | output | 1 | Access carries the uncached attribute |
| to_tlb | output | 1 | Access must be translated by the lookup buffer |

## Verification
The hardest case to reach is the one where the kernel-forcing status bits and the privilege field disagree, for example a user field combined with bit 28 set. Only then does an access to the cached kernel window at a non-kernel field value have to pass without error. Uniformly random status words almost always set one of the forcing bits, so the stimulus sets each forcing bit with low probability and draws the two-bit field on its own. It also steers a large share of the addresses into the two kernel windows, so that the privilege check is exercised often. Directed vectors cover every field value combined with each forcing bit taken alone, the edges of the windows, and misalignment at every width.

// File: rtl/seg_chk_pkg.sv
// Package: shared types and constants for the segment and privilege checker.
// Assumes a 32-bit virtual address space with 3-bit segment tags.
package seg_chk_pkg;

    localparam int VA_W     = 32;
    localparam int STATUS_W = 32;
    localparam int SIZE_W   = 2;
    localparam int TAG_W    = 3;

    // Status bits that force kernel level regardless of the privilege field
    localparam logic [STATUS_W-1:0] KFORCE_MASK = 32'h1000_0006;
    localparam int PRIV_LSB = 3;

    // Segment tags (top three address bits)
    localparam logic [TAG_W-1:0] TAG_KCACHED   = 3'b100;
    localparam logic [TAG_W-1:0] TAG_KUNCACHED = 3'b101;

    // Address bits that together select the uncached attribute
    localparam int UNC_BIT_HI = 31;
    localparam int UNC_BIT_LO = 29;

    typedef enum logic [1:0] {
        PRIV_KERNEL = 2'd0,
        PRIV_SUPER  = 2'd1,
        PRIV_USER   = 2'd2,
        PRIV_UNDEF  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

endpackage

// File: rtl/seg_priv_decode.sv
// Module: seg_priv_decode
// Decodes the privilege level of an access from the status word.
// Assumes the forcing bits override the two-bit privilege field.
module seg_priv_decode
    import seg_chk_pkg::*;
#(
    parameter int SW  = STATUS_W,
    parameter int LSB = PRIV_LSB
) (
    input  logic [SW-1:0] status_word,
    output priv_e         priv
);

    logic          forced;
    logic [1:0]    field;

    assign forced = |(status_word & SW'(KFORCE_MASK));
    assign field  = status_word[LSB+1:LSB];

    // Pick the level: forcing bits first, then the field value
    always_comb begin
        if (forced) begin
            priv = PRIV_KERNEL;
        end else begin
            case (field)
                2'b00:   priv = PRIV_KERNEL;
                2'b01:   priv = PRIV_SUPER;
                2'b10:   priv = PRIV_USER;
                default: priv = PRIV_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/seg_align_check.sv
// Module: seg_align_check
// Flags an address that is not a multiple of the access width.
// Assumes the width code is the log2 of the byte count.
module seg_align_check #(
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input  logic [AW-1:0]  vaddr,
    input  logic [SZW-1:0] size_code,
    output logic           misaligned
);

    localparam int NUM_SIZES = 1 << SZW;

    logic [NUM_SIZES-1:0] mis_vec;

    // One low-bit test per supported width
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
        localparam logic [AW-1:0] LOW_MASK = (AW'(1) << k) - AW'(1);
        assign mis_vec[k] = |(vaddr & LOW_MASK);
    end

    assign misaligned = mis_vec[size_code];

endmodule

// File: rtl/seg_region_decode.sv
// Module: seg_region_decode
// Classifies the address into the unmapped kernel windows or mapped space
// and forms the direct physical address. Assumes 3-bit segment tags.
module seg_region_decode
    import seg_chk_pkg::*;
#(
    parameter int AW = VA_W,
    parameter int TW = TAG_W
) (
    input  logic [AW-1:0] vaddr,
    output logic          in_kcached,
    output logic          in_kuncached,
    output logic [AW-1:0] direct_pa,
    output logic          unc_attr
);

    logic [TW-1:0] tag;

    assign tag = vaddr[AW-1:AW-TW];

    // Segment membership from the tag bits
    always_comb begin
        in_kcached   = (tag == TAG_KCACHED);
        in_kuncached = (tag == TAG_KUNCACHED);
    end

    // Direct mapping: strip the tag, zero outside the windows
    always_comb begin
        if (in_kcached || in_kuncached) begin
            direct_pa = {{TW{1'b0}}, vaddr[AW-TW-1:0]};
        end else begin
            direct_pa = '0;
        end
    end

    assign unc_attr = vaddr[UNC_BIT_HI] & vaddr[UNC_BIT_LO];

endmodule

// File: rtl/seg_priv_check.sv
// Module: seg_priv_check (top)
// Front-end address check ahead of translation: privilege decode,
// alignment, unmapped window bypass, uncached marking and routing.
// Assumes purely combinational use; no state is held.
module seg_priv_check
    import seg_chk_pkg::*;
(
    input  logic [31:0] vaddr,
    input  logic [1:0]  size_code,
    input  logic [1:0]  acc_kind,
    input  logic [31:0] status_word,
    output logic        bypass,
    output logic [31:0] phys_addr,
    output logic        addr_err,
    output logic        err_store,
    output logic [31:0] bad_vaddr,
    output logic        uncacheable,
    output logic        to_tlb
);

    priv_e       priv;
    logic        misaligned;
    logic        in_kcached;
    logic        in_kuncached;
    logic        unc_attr;
    logic        priv_fault;
    logic [31:0] direct_pa;

    seg_priv_decode #(.SW(STATUS_W), .LSB(PRIV_LSB)) u_priv (
        .status_word (status_word),
        .priv        (priv)
    );

    seg_align_check #(.AW(VA_W), .SZW(SIZE_W)) u_align (
        .vaddr      (vaddr),
        .size_code  (size_code),
        .misaligned (misaligned)
    );

    seg_region_decode #(.AW(VA_W), .TW(TAG_W)) u_region (
        .vaddr        (vaddr),
        .in_kcached   (in_kcached),
        .in_kuncached (in_kuncached),
        .direct_pa    (direct_pa),
        .unc_attr     (unc_attr)
    );

    // Privilege violation: cached kernel window below kernel level
    assign priv_fault = in_kcached && (priv != PRIV_KERNEL);

    // Error flags and faulting address
    always_comb begin
        addr_err  = misaligned || priv_fault;
        err_store = addr_err && (acc_kind == ACC_STORE);
        bad_vaddr = addr_err ? vaddr : '0;
    end

    // Routing: bypass window, translation path, cache attribute
    always_comb begin
        bypass      = in_kcached || in_kuncached;
        phys_addr   = direct_pa;
        to_tlb      = !bypass && !addr_err;
        uncacheable = unc_attr && !addr_err;
    end

endmodule

// File: rtl/seg_priv_check_sva.sv
// Module: seg_priv_check_sva
// Checker bound to seg_priv_check; relates the output flags to each other
// and to the inputs. Combinational immediate checks, as the block has no clock.
module seg_priv_check_sva (
    input logic [31:0] vaddr,
    input logic [1:0]  acc_kind,
    input logic        bypass,
    input logic [31:0] phys_addr,
    input logic        addr_err,
    input logic        err_store,
    input logic [31:0] bad_vaddr,
    input logic        uncacheable,
    input logic        to_tlb
);

    // Cross-output consistency
    always_comb begin
        AST_TLB_NOT_ON_ERR: assert (!(to_tlb && addr_err));                            // R9
        AST_TLB_NOT_ON_BYPASS: assert (!(to_tlb && bypass));                           // R9
        AST_DIRECT_PA: assert (!bypass || (phys_addr == {3'b000, vaddr[28:0]}));       // R5
        AST_NO_PA_MAPPED: assert (bypass || (phys_addr == 32'h0));                     // R5
        AST_STORE_CODE: assert (!err_store || (addr_err && acc_kind == 2'b10));        // R6
        AST_BAD_VA: assert (addr_err ? (bad_vaddr == vaddr) : (bad_vaddr == 32'h0));   // R7
        AST_UNC_BITS: assert (!uncacheable || (vaddr[31] && vaddr[29] && !addr_err));  // R8
        AST_KSEG1_PRIV: assert (!(vaddr[31:29] == 3'b101 && vaddr[2:0] == 3'b000) || !addr_err); // R4
    end

endmodule

bind seg_priv_check seg_priv_check_sva u_sva (
    .vaddr       (vaddr),
    .acc_kind    (acc_kind),
    .bypass      (bypass),
    .phys_addr   (phys_addr),
    .addr_err    (addr_err),
    .err_store   (err_store),
    .bad_vaddr   (bad_vaddr),
    .uncacheable (uncacheable),
    .to_tlb      (to_tlb)
);

// File: tb/seg_priv_check_bench.sv
// Bench for seg_priv_check: directed corners plus seeded random vectors,
// compared against expected values from bench functions.
module seg_priv_check_bench;

    logic        clk = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  size_code = '0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] status_word = '0;
    logic        bypass, addr_err, err_store, uncacheable, to_tlb;
    logic [31:0] phys_addr, bad_vaddr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    seg_priv_check u_seg_priv_check (
        .vaddr       (vaddr),
        .size_code   (size_code),
        .acc_kind    (acc_kind),
        .status_word (status_word),
        .bypass      (bypass),
        .phys_addr   (phys_addr),
        .addr_err    (addr_err),
        .err_store   (err_store),
        .bad_vaddr   (bad_vaddr),
        .uncacheable (uncacheable),
        .to_tlb      (to_tlb)
    );

    // Expected-value functions written from the requirements
    function automatic bit exp_kernel(input logic [31:0] st);
        return st[28] || st[2] || st[1] || (st[4:3] == 2'b00);    // R1, R2
    endfunction

    function automatic bit exp_in_window(input logic [31:0] va);
        return (va >= 32'h8000_0000) && (va <= 32'hBFFF_FFFF);
    endfunction

    function automatic bit exp_err(input logic [31:0] va, input logic [1:0] sz,
                                   input logic [31:0] st);
        bit mis;
        bit prv;
        mis = (va % (32'd1 << sz)) != 0;                                   // R3
        prv = (va >= 32'h8000_0000) && (va <= 32'h9FFF_FFFF) && !exp_kernel(st); // R4
        return mis || prv;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (va=%h sz=%0d acc=%0d st=%h)",
                     req, act, exp, vaddr, size_code, acc_kind, status_word);
        end
    endtask

    // Drive one vector away from the edge, then compare every output
    task automatic apply(input logic [31:0] va, input logic [1:0] sz,
                         input logic [1:0] acc, input logic [31:0] st, input string tag);
        bit e_err, e_win;
        @(negedge clk);
        vaddr = va; size_code = sz; acc_kind = acc; status_word = st;
        #1;
        e_err = exp_err(va, sz, st);
        e_win = exp_in_window(va);
        chk({tag, " R3/R4 addr_err"}, 32'(addr_err), 32'(e_err));
        chk("R5 bypass", 32'(bypass), 32'(e_win));
        chk("R5 phys_addr", phys_addr, e_win ? (va & 32'h1FFF_FFFF) : 32'h0);
        chk("R6 err_store", 32'(err_store), 32'(e_err && acc == 2'b10));
        chk("R7 bad_vaddr", bad_vaddr, e_err ? va : 32'h0);
        chk("R8 uncacheable", 32'(uncacheable), 32'(va[31] && va[29] && !e_err));
        chk("R9 to_tlb", 32'(to_tlb), 32'(!e_win && !e_err));
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stimulus
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5EC0_1234);
        // Idle state with all-zero inputs: mapped, kernel, aligned
        apply(32'h0000_0000, 2'd0, 2'b00, 32'h0, "R9 idle");
        // R1: each forcing bit alone with the user field
        apply(32'h8000_0100, 2'd2, 2'b01, 32'h1000_0010, "R1 bit28");
        apply(32'h8000_0100, 2'd2, 2'b01, 32'h0000_0014, "R1 bit2");
        apply(32'h8000_0100, 2'd2, 2'b01, 32'h0000_0012, "R1 bit1");
        apply(32'h9FFF_FFF8, 2'd3, 2'b10, 32'h0000_0000, "R1 field0");
        // R2: supervisor, user and undefined levels hit the cached window
        apply(32'h8000_0000, 2'd0, 2'b00, 32'h0000_0008, "R2 super");
        apply(32'h9FFF_FFFF, 2'd0, 2'b10, 32'h0000_0010, "R2 user store");
        apply(32'h8123_4560, 2'd3, 2'b01, 32'h0000_0018, "R2 undef");
        // R4: uncached window at user level passes
        apply(32'hA000_0000, 2'd3, 2'b01, 32'h0000_0010, "R4 kseg1 user");
        apply(32'hBFFF_FFFC, 2'd2, 2'b10, 32'h0000_0010, "R4 kseg1 edge");
        // R3: misalignment at each width, store and fetch
        apply(32'h0000_1004, 2'd3, 2'b10, 32'h0, "R3 8B off4");
        apply(32'h0000_1002, 2'd2, 2'b00, 32'h0, "R3 4B off2");
        apply(32'h0000_1001, 2'd1, 2'b11, 32'h0, "R3 2B off1");
        apply(32'hFFFF_FFFF, 2'd0, 2'b01, 32'h10, "R3 1B any");
        apply(32'hA000_0001, 2'd1, 2'b10, 32'h0, "R3 kseg1 mis");
        // R5/R9 boundaries of the windows
        apply(32'h7FFF_FFFF, 2'd0, 2'b01, 32'h10, "R9 below");
        apply(32'hC000_0000, 2'd0, 2'b01, 32'h10, "R9 above");
        apply(32'hE000_0000, 2'd2, 2'b01, 32'h10, "R8 mapped unc");

        // Seeded random vectors, biased towards the windows and rare forcing bits
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] va, st;
            va = $urandom();
            if ($urandom_range(0, 1) == 1) va[31:30] = 2'b10;
            if ($urandom_range(0, 1) == 1) va[2:0] = 3'b000;
            st = $urandom() & ~32'h1000_0006;
            if ($urandom_range(0, 7) == 0) st[28] = 1'b1;
            if ($urandom_range(0, 7) == 0) st[2]  = 1'b1;
            if ($urandom_range(0, 7) == 0) st[1]  = 1'b1;
            apply(va, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), st, "R1/R2 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule